// File: doc/BRIEF.md
# Pattern Fill-Verify Memory Sequencer

This block drives a self-test of a memory region through a 32-bit word port. It runs seven passes in a fixed order. Each pass writes a generated value into every word of a window, then reads every word back and compares it with the value generated again. The first mismatch ends the whole test. The failing byte address, the value that was expected and the value that came back are then held at the outputs for diagnosis.

The tested size comes from the installed memory size given at start. That size is capped at a parameterised limit (256 blocks of 1 MiB by default), and one block is then taken off. In full mode a single window sweeps the entire tested size from address zero. In sparse mode only two small windows are visited for each block: one at the block's start and one that ends at the next block boundary (2 KiB each by default). All seven passes run on a window before the next window begins.

While it works, the block emits a short pulse every 1024 words so that an external watchdog can be kept alive. When the test completes it raises `done` for one cycle, and `ok` reports the result.

Top module: `mem_pattern_seq`

## Requirements
- R1: The passes run in this order, with these write values: 0x00000000, 0xFFFFFFFF, 0x55555555, 0xAAAAAAAA, `1 << (idx mod 32)`, `idx`, and `~idx`. Here `idx` is the word index.
- R2: Each pass writes every word of the window in ascending address order (`memWe`=1), then reads every word in the same order (`memWe`=0). All seven passes finish on one window before the next window starts.
- R3: `idx` counts words from the start of the current window. It is not derived from the absolute address.
- R4: The tested size is min(`memSize`, CAP_BLOCKS blocks) minus one block, and it saturates at zero. Full mode (`sparse`=0) sweeps that many bytes starting at address 0.
- R5: Sparse mode (`sparse`=1) visits, for block k = 0..(tested/block)-1, first the window at k·block and then the window at (k+1)·block − window size.
- R6: On the first read whose data differs from the expected value, the test stops and issues no further accesses. `ok` goes low, and `failAddr`, `failExp` and `failGot` hold that read's byte address, expected value and returned value.
- R7: `done` is high for exactly one cycle at the end of each test. `ok` is then 1 if no mismatch occurred.
- R8: `ok` and the three fail outputs do not change from the end of a test until the next accepted start. That start clears the fail outputs to zero.
- R9: `kick` pulses for one cycle after each accepted access whose word index is a multiple of 2^KICK_SHIFT (1024 by default), in both phases.
- R10: An access is held with `memReq` high, and `memAddr`, `memWe` and `memWdata` unchanged, until `memAck` is seen. Only one access is outstanding at a time.
- R11: `start` is ignored while a test is running.
- R12: If the tested size is zero, or sparse mode has no whole block, `done` pulses with `ok`=1 and no access is made.
- R13: After reset, `memReq`, `done`, `kick` and `ok` are 0, and the fail outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a test (sampled while idle) |
| sparse | input | 1 | 1 = edge windows per block, 0 = full sweep |
| memSize | input | ADDR_W | Installed memory size in bytes |
| memReq | output | 1 | Access request, held until acknowledged |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | ADDR_W | Byte address of the access |
| memWdata | output | 32 | Write data |
| memAck | input | 1 | Access completed; read data valid |
| memRdata | input | 32 | Read data, valid with `memAck` |
| done | output | 1 | One-cycle end-of-test pulse |
| ok | output | 1 | Test result, 1 = no mismatch |
| failAddr | output | ADDR_W | Byte address of the first mismatch |
| failExp | output | 32 | Expected value at the mismatch |
| failGot | output | 32 | Value read at the mismatch |
| kick | output | 1 | Watchdog keep-alive pulse |

## Verification
The hard cases are a mismatch that only a late pass can reveal, and one that sits in a far window of a sparse sweep. A clean memory never produces either. The bench's memory model therefore forces single bits at one chosen address to stuck-at-one or stuck-at-zero. A stuck-at-zero bit survives the all-zeros pass and is caught only on the all-ones pass. A stuck-at-one bit placed in the upper window of the second block is reached only after three clean windows. The scoreboard builds the full expected access list, including the point where it must stop, from the same fault model.

// File: rtl/mps_pkg.sv
package mps_pkg;

  localparam int NUM_PASSES = 7;

  typedef struct packed {
    logic load;   // capture configuration, clear result
    logic fire;   // an access was acknowledged this cycle
    logic step;   // advance word / phase / pass / window
    logic grab;   // record a mismatch
    logic win;    // mark the test as passed
  } mtStrobe_t;

  function automatic logic [31:0] passValue(input logic [2:0] passSel,
                                            input logic [31:0] idx);
    case (passSel)
      3'd0:    passValue = 32'h0000_0000;
      3'd1:    passValue = 32'hFFFF_FFFF;
      3'd2:    passValue = 32'h5555_5555;
      3'd3:    passValue = 32'hAAAA_AAAA;
      3'd4:    passValue = 32'd1 << idx[4:0];
      3'd5:    passValue = idx;
      3'd6:    passValue = ~idx;
      default: passValue = 32'h0000_0000;
    endcase
  endfunction

endpackage

// File: rtl/mps_ctrl.sv
module mps_ctrl
  import mps_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       memAck,
  input  logic       empty,
  input  logic       finalAcc,
  input  logic       readPhase,
  input  logic       mismatch,
  output mtStrobe_t  strobe,
  output logic       memReq,
  output logic       done
);

  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_ACCESS, S_FIN} state_t;
  state_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    case (state)
      S_IDLE: begin
        if (start) begin
          strobe.load = 1'b1;
          stateNext   = S_CHECK;
        end
      end
      S_CHECK: stateNext = empty ? S_FIN : S_ACCESS;
      S_ACCESS: begin
        if (memAck) begin
          strobe.fire = 1'b1;
          if (readPhase && mismatch) begin
            strobe.grab = 1'b1;
            stateNext   = S_FIN;
          end else if (finalAcc) begin
            strobe.win = 1'b1;
            stateNext  = S_FIN;
          end else begin
            strobe.step = 1'b1;
          end
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  assign memReq = (state == S_ACCESS);
  assign done   = (state == S_FIN);

endmodule

// File: rtl/mps_datapath.sv
module mps_datapath
  import mps_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BLOCK_SHIFT = 20,
  parameter int CAP_BLOCKS  = 256,
  parameter int WIN_SHIFT   = 11,
  parameter int KICK_SHIFT  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sparse,
  input  logic [ADDR_W-1:0] memSize,
  input  mtStrobe_t         strobe,
  input  logic [31:0]       memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic [31:0]       memWdata,
  output logic              ok,
  output logic [ADDR_W-1:0] failAddr,
  output logic [31:0]       failExp,
  output logic [31:0]       failGot,
  output logic              kick,
  output logic              empty,
  output logic              finalAcc,
  output logic              readPhase,
  output logic              mismatch
);

  localparam logic [ADDR_W:0]   BLOCK_BYTES = (ADDR_W+1)'(1) << BLOCK_SHIFT;
  localparam logic [ADDR_W:0]   CAP_BYTES   = (ADDR_W+1)'(CAP_BLOCKS) << BLOCK_SHIFT;
  localparam logic [ADDR_W-1:0] WIN_BYTES   = ADDR_W'(1) << WIN_SHIFT;
  localparam logic [ADDR_W-1:0] WIN_WORDS   = ADDR_W'(1) << (WIN_SHIFT - 2);
  localparam logic [ADDR_W-1:0] EDGE_OFS    = ADDR_W'(BLOCK_BYTES) - WIN_BYTES;

  logic              sparseQ;
  logic [ADDR_W-1:0] winCount, winWords, winIdx, wordIdx;
  logic [2:0]        passSel;
  logic [ADDR_W:0]   sizeExt, capped, tested, blocks;
  logic [ADDR_W-1:0] loadCount, loadWords, winBase;
  logic [31:0]       expVal;
  logic              lastWord, lastPass, lastWin;

  // Region sizing, evaluated from the inputs at load time
  always_comb begin
    sizeExt   = {1'b0, memSize};
    capped    = (sizeExt > CAP_BYTES) ? CAP_BYTES : sizeExt;
    tested    = (capped >= BLOCK_BYTES) ? (capped - BLOCK_BYTES) : '0;
    blocks    = tested >> BLOCK_SHIFT;
    loadWords = sparse ? WIN_WORDS : ADDR_W'(tested >> 2);
    loadCount = sparse ? ADDR_W'(blocks << 1)
                       : ((tested >> 2) != '0 ? ADDR_W'(1) : '0);
  end

  assign winBase  = sparseQ ? (((winIdx >> 1) << BLOCK_SHIFT) + (winIdx[0] ? EDGE_OFS : '0))
                            : '0;
  assign memAddr  = winBase + (wordIdx << 2);
  assign memWe    = !readPhase;
  assign expVal   = passValue(passSel, 32'(wordIdx));
  assign memWdata = expVal;
  assign mismatch = (memRdata != expVal);

  assign lastWord = (wordIdx == winWords - 1'b1);
  assign lastPass = (passSel == 3'(NUM_PASSES - 1));
  assign lastWin  = (winIdx == winCount - 1'b1);
  assign finalAcc = lastWord && readPhase && lastPass && lastWin;
  assign empty    = (winCount == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sparseQ   <= 1'b0;
      winCount  <= '0;
      winWords  <= '0;
      winIdx    <= '0;
      wordIdx   <= '0;
      passSel   <= '0;
      readPhase <= 1'b0;
      ok        <= 1'b0;
      failAddr  <= '0;
      failExp   <= '0;
      failGot   <= '0;
      kick      <= 1'b0;
    end else begin
      kick <= strobe.fire && (wordIdx[KICK_SHIFT-1:0] == '0);
      if (strobe.load) begin
        sparseQ   <= sparse;
        winCount  <= loadCount;
        winWords  <= loadWords;
        winIdx    <= '0;
        wordIdx   <= '0;
        passSel   <= '0;
        readPhase <= 1'b0;
        ok        <= (loadCount == '0);
        failAddr  <= '0;
        failExp   <= '0;
        failGot   <= '0;
      end
      if (strobe.step) begin
        if (lastWord) begin
          wordIdx <= '0;
          if (!readPhase) begin
            readPhase <= 1'b1;
          end else begin
            readPhase <= 1'b0;
            if (lastPass) begin
              passSel <= '0;
              winIdx  <= winIdx + 1'b1;
            end else begin
              passSel <= passSel + 1'b1;
            end
          end
        end else begin
          wordIdx <= wordIdx + 1'b1;
        end
      end
      if (strobe.grab) begin
        failAddr <= memAddr;
        failExp  <= expVal;
        failGot  <= memRdata;
      end
      if (strobe.win) ok <= 1'b1;
    end
  end

endmodule

// File: rtl/mem_pattern_seq.sv
module mem_pattern_seq
  import mps_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BLOCK_SHIFT = 20,
  parameter int CAP_BLOCKS  = 256,
  parameter int WIN_SHIFT   = 11,
  parameter int KICK_SHIFT  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              sparse,
  input  logic [ADDR_W-1:0] memSize,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  input  logic              memAck,
  input  logic [31:0]       memRdata,
  output logic              done,
  output logic              ok,
  output logic [ADDR_W-1:0] failAddr,
  output logic [31:0]       failExp,
  output logic [31:0]       failGot,
  output logic              kick
);

  mtStrobe_t strobe;
  logic empty, finalAcc, readPhase, mismatch;

  mps_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .memAck(memAck),
    .empty(empty), .finalAcc(finalAcc), .readPhase(readPhase),
    .mismatch(mismatch), .strobe(strobe), .memReq(memReq), .done(done)
  );

  mps_datapath #(
    .ADDR_W(ADDR_W), .BLOCK_SHIFT(BLOCK_SHIFT), .CAP_BLOCKS(CAP_BLOCKS),
    .WIN_SHIFT(WIN_SHIFT), .KICK_SHIFT(KICK_SHIFT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .sparse(sparse), .memSize(memSize),
    .strobe(strobe), .memRdata(memRdata), .memAddr(memAddr), .memWe(memWe),
    .memWdata(memWdata), .ok(ok), .failAddr(failAddr), .failExp(failExp),
    .failGot(failGot), .kick(kick), .empty(empty), .finalAcc(finalAcc),
    .readPhase(readPhase), .mismatch(mismatch)
  );

endmodule

// File: rtl/mps_checker.sv
module mps_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              memReq,
  input logic              memWe,
  input logic              memAck,
  input logic [ADDR_W-1:0] memAddr,
  input logic [31:0]       memWdata,
  input logic              done,
  input logic              ok,
  input logic [ADDR_W-1:0] failAddr,
  input logic [31:0]       failExp,
  input logic [31:0]       failGot,
  input logic              kick
);

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata)));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_idle_at_done_R12: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !memReq);

  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!start && !(memReq && memAck)) |=>
      ($stable(ok) && $stable(failAddr) && $stable(failExp) && $stable(failGot)));

  assert_kick_source_R9: assert property (@(posedge clk) disable iff (!rstN)
    kick |-> $past(memReq && memAck));

endmodule

bind mem_pattern_seq mps_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .memReq(memReq), .memWe(memWe),
  .memAck(memAck), .memAddr(memAddr), .memWdata(memWdata), .done(done),
  .ok(ok), .failAddr(failAddr), .failExp(failExp), .failGot(failGot), .kick(kick)
);

// File: tb/tb_mem_pattern_seq.sv
`timescale 1ns/1ps
module tb_mem_pattern_seq;

  localparam int ADDR_W = 16;
  localparam int BLK    = 256;   // bytes per block (BLOCK_SHIFT 8)
  localparam int CAPB   = 4;     // cap in blocks
  localparam int WINB   = 16;    // window bytes (WIN_SHIFT 4)
  localparam int KICKW  = 8;     // kick interval in words (KICK_SHIFT 3)

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, sparse = 1'b0;
  logic [ADDR_W-1:0] memSize = '0;
  logic memReq, memWe, memAck, done, ok, kick;
  logic [ADDR_W-1:0] memAddr, failAddr;
  logic [31:0] memWdata, memRdata, failExp, failGot;

  always #10 clk = ~clk;   // 50 MHz

  mem_pattern_seq #(.ADDR_W(ADDR_W), .BLOCK_SHIFT(8), .CAP_BLOCKS(CAPB),
                    .WIN_SHIFT(4), .KICK_SHIFT(3)) dut (
    .clk(clk), .rstN(rstN), .start(start), .sparse(sparse), .memSize(memSize),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memAck(memAck), .memRdata(memRdata), .done(done), .ok(ok),
    .failAddr(failAddr), .failExp(failExp), .failGot(failGot), .kick(kick));

  // Memory model with one faulty address: stuck-at-one and stuck-at-zero masks
  logic [31:0] mem [0:255];
  logic [ADDR_W-1:0] faultAddr = 16'hFFFF;
  logic [31:0] orMask = '0, andMask = '0;

  always @(posedge clk) begin
    if (!rstN) begin
      memAck   <= 1'b0;
      memRdata <= '0;
    end else if (memReq && !memAck) begin
      memAck <= 1'b1;
      if (memWe) mem[memAddr[9:2]] <= memWdata;
      else if (memAddr == faultAddr) memRdata <= (mem[memAddr[9:2]] | orMask) & ~andMask;
      else memRdata <= mem[memAddr[9:2]];
    end else begin
      memAck <= 1'b0;
    end
  end

  typedef struct { logic we; logic [ADDR_W-1:0] addr; logic [31:0] data; } acc_t;
  acc_t expQ[$];

  int checks = 0, fails = 0;
  int kicksSeen = 0, accSeen = 0, doneSeen = 0;
  int expKicks, expAcc;
  bit expOk;
  logic [ADDR_W-1:0] expFailAddr;
  logic [31:0] expFailExp, expFailGot;
  string curTag = "R13";
  bit finished = 0;

  task automatic check(input bit cond, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] benchPat(input int p, input int i);
    case (p)
      0: return 32'h0;
      1: return 32'hFFFFFFFF;
      2: return 32'h55555555;
      3: return 32'hAAAAAAAA;
      4: return 32'd1 << (i % 32);
      5: return 32'(i);
      default: return ~32'(i);
    endcase
  endfunction

  // Driver side of the scoreboard: builds the expected access stream
  task automatic planRun(input bit sp, input int size);
    int capped, tested, nWin, words, base, a;
    logic [31:0] v, got;
    acc_t e;
    expQ.delete();
    expOk = 1; expKicks = 0; expAcc = 0;
    expFailAddr = '0; expFailExp = '0; expFailGot = '0;
    capped = (size > CAPB * BLK) ? CAPB * BLK : size;
    tested = (capped >= BLK) ? capped - BLK : 0;
    if (sp) begin nWin = 2 * (tested / BLK); words = WINB / 4; end
    else begin nWin = (tested / 4 > 0) ? 1 : 0; words = tested / 4; end
    for (int w = 0; w < nWin; w++) begin
      base = sp ? ((w / 2) * BLK + ((w % 2) ? BLK - WINB : 0)) : 0;
      for (int p = 0; p < 7; p++) begin
        for (int i = 0; i < words; i++) begin
          e.we = 1; e.addr = ADDR_W'(base + 4 * i); e.data = benchPat(p, i);
          expQ.push_back(e); expAcc++;
          if (i % KICKW == 0) expKicks++;
        end
        for (int i = 0; i < words; i++) begin
          a = base + 4 * i; v = benchPat(p, i);
          got = (ADDR_W'(a) == faultAddr) ? ((v | orMask) & ~andMask) : v;
          e.we = 0; e.addr = ADDR_W'(a); e.data = v;
          expQ.push_back(e); expAcc++;
          if (i % KICKW == 0) expKicks++;
          if (got != v) begin
            expOk = 0; expFailAddr = ADDR_W'(a); expFailExp = v; expFailGot = got;
            return;
          end
        end
      end
    end
  endtask

  // Monitor side: pops and compares each accepted access
  logic prevPend = 0;
  logic [ADDR_W-1:0] prevAddr = '0;
  initial begin
    acc_t e;
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (kick) kicksSeen++;
        if (done) doneSeen++;
        if (prevPend) check(memReq && memAddr == prevAddr, "R10 held request", 32'(memAddr), 32'(prevAddr));
        prevPend = memReq && !memAck;
        prevAddr = memAddr;
        if (memReq && memAck) begin
          accSeen++;
          if (expQ.size() == 0) begin
            check(0, "R2 unexpected access", 32'(memAddr), 32'hFFFFFFFF);
          end else begin
            e = expQ.pop_front();
            check(memWe == e.we && memAddr == e.addr, {curTag, " R2 order"},
                  {15'd0, memWe, memAddr}, {15'd0, e.we, e.addr});
            if (e.we) check(memWdata == e.data, "R1 R3 write data", memWdata, e.data);
          end
        end
      end
    end
  end

  task automatic runTest(input string tag, input bit sp, input int size, input bit midPulse);
    int n = 0;
    curTag = tag;
    planRun(sp, size);
    kicksSeen = 0; accSeen = 0; doneSeen = 0;
    @(negedge clk);
    sparse = sp; memSize = ADDR_W'(size); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && n < 20000) begin
      if (midPulse && n == 40) start = 1'b1;
      else start = 1'b0;
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    check(done, {tag, " R7 done seen"}, 32'(done), 1);
    check(ok == expOk, {tag, " R7 ok"}, 32'(ok), 32'(expOk));
    if (!expOk) begin
      check(failAddr == expFailAddr, "R6 failAddr", 32'(failAddr), 32'(expFailAddr));
      check(failExp == expFailExp, "R6 failExp", failExp, expFailExp);
      check(failGot == expFailGot, "R6 failGot", failGot, expFailGot);
    end
    @(negedge clk);
    check(!done, "R7 single-cycle done", 32'(done), 0);
    check(doneSeen == 1, "R11 one done per start", 32'(doneSeen), 1);
    check(accSeen == expAcc, {tag, " R2 access count"}, 32'(accSeen), 32'(expAcc));
    check(expQ.size() == 0, "R6 no pending expected", 32'(expQ.size()), 0);
    check(kicksSeen == expKicks, "R9 kick count", 32'(kicksSeen), 32'(expKicks));
  endtask

  initial begin
    logic [ADDR_W-1:0] fa;
    logic [31:0] fe, fg;
    repeat (3) @(negedge clk);
    check(!memReq && !done && !kick && !ok, "R13 reset controls", {memReq, done, kick, ok}, 0);
    check(failAddr == 0 && failExp == 0 && failGot == 0, "R13 reset fail outputs", failGot, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!memReq && !done, "R13 idle after reset", {memReq, done}, 0);

    runTest("R4", 0, 2 * BLK, 0);          // full, one block tested
    runTest("R4", 0, 8 * BLK, 0);          // full, capped at 4 blocks
    runTest("R5", 1, 3 * BLK, 0);          // sparse, two blocks, R3 window-relative index
    runTest("R5", 1, 16 * BLK, 1);         // sparse capped, start pulsed while busy (R11)
    runTest("R12", 0, 200, 0);             // below one block
    runTest("R12", 1, BLK + 64, 0);        // sparse with no whole block

    // Stuck-at-zero bit 5: survives all-zeros pass, caught on all-ones (R6)
    faultAddr = 16'h0040; orMask = '0; andMask = 32'h20;
    runTest("R6", 0, 8 * BLK, 0);
    fa = failAddr; fe = failExp; fg = failGot;
    accSeen = 0;
    repeat (30) @(negedge clk);
    check(accSeen == 0, "R6 halted after mismatch", 32'(accSeen), 0);
    check(failAddr == fa && failExp == fe && failGot == fg && !ok, "R8 result held",
          failGot, fg);

    // Next start clears fail outputs (R8)
    faultAddr = 16'hFFFF; andMask = '0;
    runTest("R12", 0, 0, 0);
    check(failAddr == 0 && failExp == 0 && failGot == 0, "R8 cleared by start",
          failExp, 0);

    // Stuck-at-one bit 8 in upper window of second block (R5, R6)
    faultAddr = 16'h01F4; orMask = 32'h100;
    runTest("R6", 1, 3 * BLK, 0);

    // Stuck-at-zero bit 0 caught in full sweep over one block
    faultAddr = 16'h000C; orMask = '0; andMask = 32'h1;
    runTest("R6", 0, 2 * BLK, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule